// File: doc/BRIEF.md
# Buffered Page Program Controller

This block writes a byte range of arbitrary start and length into a page-organised serial flash that holds a one-page SRAM buffer inside the device. It cuts the range into page-sized chunks. The first chunk starts at the in-page offset of the start address. Each full page after it is one chunk, and whatever is left over forms the last chunk. A chunk that covers only part of a page needs one extra step first: the controller copies the stored page into the device buffer. Only after that does it stream the new bytes with a program-through-buffer command, so the bytes of the page outside the chunk survive the page rewrite. After each device operation the controller polls the status byte until the device reports ready. When verify is enabled, it also asks the device to compare the page with its buffer and checks the mismatch flag.

Write data enters on a valid/ready byte stream. An external serial shifter carries the link. Each byte exchange on it completes in a cycle where `link_valid` and `link_ready` are both high, and `link_rx` then holds the byte clocked in during that exchange. `link_sel` is the active-high chip select.

The device address is 24 bits wide and is sent most significant byte first. A page index is shifted left by `PAGE_OFS_BITS`, and the in-page offset is added to it.

Top module: `pgprog_ctrl`

## Requirements
- R1: During and straight after reset: `busy`, `done`, `link_sel`, `link_valid`, `wr_ready` and `cmp_err` are 0, and `bytes_written` is 0.
- R2: Chunk sizes follow the split rule. The first chunk runs from the start offset to the page end, or covers the whole request if that is shorter. Middle chunks are one full page each. The last chunk is the remainder.
- R3: A chunk shorter than `PAGE_SIZE` is preceded by a 4-byte frame: 0x53, then the 24-bit page address with its offset bits zero. A full-page chunk gets no such frame.
- R4: Each chunk is written by one frame. The frame carries 0x82, then the 3 address bytes (page index << `PAGE_OFS_BITS`, plus the offset), then exactly the chunk's bytes in stream order. `link_sel` stays high from the first to the last byte of the frame.
- R5: Every 0x53, 0x82 or 0x60 frame is followed by status frames {0xD7, 0x00}. These repeat until bit 7 of the second received byte is 1. No other command is issued before that.
- R6: With `verify_en` captured high at start, each program step is followed by a 0x60 frame carrying the page address, and then by polling. If status bit 6 is set when ready, the controller raises `cmp_err`, sets `err_page` to the page index, pulses `done`, and issues no further frames. Bit 6 is ignored in every other poll.
- R7: `bytes_written` clears at start. It grows by a chunk's length only after that chunk's program step (and its compare step, if enabled) has finished.
- R8: A zero length finishes with `done` two cycles after the start cycle, with no frame issued.
- R9: `wr_ready` is high only during the data bytes of a program frame.
- R10: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a request (sampled when idle) |
| start_addr | input | ADDR_W | Linear byte address of the first byte |
| byte_len | input | LEN_W | Number of bytes to write |
| verify_en | input | 1 | Run a compare step after each chunk |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte valid |
| wr_ready | output | 1 | Write stream byte taken |
| link_sel | output | 1 | Device chip select, active high |
| link_tx | output | 8 | Byte to send to the shifter |
| link_valid | output | 1 | Byte exchange requested |
| link_ready | input | 1 | Shifter completes the exchange this cycle |
| link_rx | input | 8 | Byte received in the completed exchange |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse at the end of a request |
| bytes_written | output | LEN_W | Bytes committed so far |
| cmp_err | output | 1 | Compare mismatch ended the request |
| err_page | output | ADDR_W | Page index that failed the compare |

## Verification
The bench builds the controller with a 6-byte page and 3 page-offset bits. The page size is therefore not a power of two, and short requests reach both partial ends, multi-page spans, the 8-page image edge and a zero length. With 8-bit address and length fields, a behavioural device model holds the whole 48-byte image. That lets the bench compare every byte of the image after each request, so damage to bytes outside a chunk shows up directly. The model also reports busy for a few polls after each operation, and it can corrupt one chosen page to force a compare failure.

// File: rtl/pgprog_pkg.sv
package pgprog_pkg;

    localparam int DEV_AW = 24;

    localparam logic [7:0] OP_PAGE_TO_BUF   = 8'h53;
    localparam logic [7:0] OP_PROG_THRU_BUF = 8'h82;
    localparam logic [7:0] OP_BUF_COMPARE   = 8'h60;
    localparam logic [7:0] OP_STATUS        = 8'hD7;

    localparam int ST_READY_BIT    = 7;
    localparam int ST_MISMATCH_BIT = 6;

    typedef logic [3:0][7:0] cmd_t;

    typedef enum logic [1:0] {F_IDLE, F_HDR, F_PAY} frm_st_e;

    typedef enum logic [2:0] {
        C_IDLE, C_PLAN, C_LOAD, C_PROG, C_CMP, C_POLL, C_ADV
    } ctl_st_e;

    typedef enum logic [1:0] {RET_LOAD, RET_PROG, RET_CMP} poll_ret_e;

    // Opcode first, then the 24-bit device address, high byte first.
    function automatic cmd_t pack_cmd(input logic [7:0] op,
                                      input logic [DEV_AW-1:0] a);
        cmd_t c;
        c[0] = op;
        c[1] = a[23:16];
        c[2] = a[15:8];
        c[3] = a[7:0];
        return c;
    endfunction

endpackage

// File: rtl/pgprog_chunker.sv
module pgprog_chunker #(
    parameter int PAGE_SIZE = 264,
    parameter int ADDR_W    = 20,
    parameter int LEN_W     = 20,
    localparam int OFS_W    = $clog2(PAGE_SIZE),
    localparam int CL_W     = $clog2(PAGE_SIZE + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic              adv,
    output logic [ADDR_W-1:0] page,
    output logic [OFS_W-1:0]  off,
    output logic [LEN_W-1:0]  remain,
    output logic [CL_W-1:0]   chunk_len,
    output logic              partial
);
    logic [LEN_W-1:0] room;
    logic [LEN_W-1:0] chunk;

    always_comb begin
        room      = LEN_W'(PAGE_SIZE) - LEN_W'(off);
        chunk     = (remain < room) ? remain : room;
        chunk_len = CL_W'(chunk);
        partial   = (chunk_len != CL_W'(PAGE_SIZE));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page   <= '0;
            off    <= '0;
            remain <= '0;
        end else if (load) begin
            page   <= addr / ADDR_W'(PAGE_SIZE);
            off    <= OFS_W'(addr % ADDR_W'(PAGE_SIZE));
            remain <= len;
        end else if (adv) begin
            page   <= page + 1'b1;
            off    <= '0;
            remain <= remain - chunk;
        end
    end

    // R2: a chunk never crosses the end of its page.
    p_chunk_in_page_r2: assert property (@(posedge clk) disable iff (rst)
        (remain != '0) |-> (32'(off) + 32'(chunk_len) <= PAGE_SIZE));

    // R2: after a chunk is consumed the next one starts at offset zero.
    p_next_at_zero_r2: assert property (@(posedge clk) disable iff (rst)
        adv |=> (off == '0));

endmodule

// File: rtl/pgprog_frame.sv
module pgprog_frame
    import pgprog_pkg::*;
#(
    parameter int CL_W = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            launch,
    input  cmd_t            hdr,
    input  logic [2:0]      hdr_cnt,
    input  logic [CL_W-1:0] pay_cnt,
    input  logic [7:0]      wr_data,
    input  logic            wr_valid,
    output logic            wr_ready,
    output logic            sel,
    output logic [7:0]      link_tx,
    output logic            link_valid,
    input  logic            link_ready,
    input  logic [7:0]      link_rx,
    output logic            fin,
    output logic [7:0]      rx_last
);
    frm_st_e         st;
    logic [2:0]      idx;
    logic [CL_W-1:0] pc;
    logic            hs;

    always_comb begin
        sel        = (st != F_IDLE);
        link_valid = (st == F_HDR) || ((st == F_PAY) && wr_valid);
        link_tx    = (st == F_PAY) ? wr_data : hdr[idx[1:0]];
        wr_ready   = (st == F_PAY) && link_ready;
        hs         = link_valid && link_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= F_IDLE;
            idx     <= '0;
            pc      <= '0;
            fin     <= 1'b0;
            rx_last <= '0;
        end else begin
            fin <= 1'b0;
            unique case (st)
                F_IDLE: if (launch) begin
                    st  <= F_HDR;
                    idx <= '0;
                    pc  <= '0;
                end
                F_HDR: if (hs) begin
                    rx_last <= link_rx;
                    idx     <= idx + 3'd1;
                    if (idx == hdr_cnt - 3'd1) begin
                        if (pay_cnt == '0) begin
                            st  <= F_IDLE;
                            fin <= 1'b1;
                        end else begin
                            st <= F_PAY;
                        end
                    end
                end
                F_PAY: if (hs) begin
                    rx_last <= link_rx;
                    pc      <= pc + 1'b1;
                    if (pc == pay_cnt - 1'b1) begin
                        st  <= F_IDLE;
                        fin <= 1'b1;
                    end
                end
                default: st <= F_IDLE;
            endcase
        end
    end

    // R5: a new frame is only requested while the link is deselected.
    p_launch_when_idle_r5: assert property (@(posedge clk) disable iff (rst)
        launch |-> !sel);

    // R4: select stays high inside the data stream of a frame.
    p_sel_through_data_r4: assert property (@(posedge clk) disable iff (rst)
        ((st == F_PAY) && !(hs && (pc == pay_cnt - 1'b1))) |=> sel);

endmodule

// File: rtl/pgprog_ctrl.sv
module pgprog_ctrl
    import pgprog_pkg::*;
#(
    parameter int PAGE_SIZE     = 264,
    parameter int PAGE_OFS_BITS = 9,
    parameter int ADDR_W        = 20,
    parameter int LEN_W         = 20,
    localparam int OFS_W        = $clog2(PAGE_SIZE),
    localparam int CL_W         = $clog2(PAGE_SIZE + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  byte_len,
    input  logic              verify_en,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic              link_sel,
    output logic [7:0]        link_tx,
    output logic              link_valid,
    input  logic              link_ready,
    input  logic [7:0]        link_rx,
    output logic              busy,
    output logic              done,
    output logic [LEN_W-1:0]  bytes_written,
    output logic              cmp_err,
    output logic [ADDR_W-1:0] err_page
);
    ctl_st_e   st;
    poll_ret_e ret;
    logic      armed;
    logic      verify_q;

    logic [ADDR_W-1:0] page;
    logic [OFS_W-1:0]  off;
    logic [LEN_W-1:0]  remain;
    logic [CL_W-1:0]   chunk_len;
    logic              partial;

    logic              launch;
    logic              fin;
    logic [7:0]        rx_last;
    cmd_t              f_hdr;
    logic [2:0]        f_cnt;
    logic [CL_W-1:0]   f_pay;
    logic [DEV_AW-1:0] dev_page;
    logic [DEV_AW-1:0] dev_full;

    pgprog_chunker #(
        .PAGE_SIZE (PAGE_SIZE),
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W)
    ) u_chunk (
        .clk       (clk),
        .rst       (rst),
        .load      ((st == C_IDLE) && start),
        .addr      (start_addr),
        .len       (byte_len),
        .adv       (st == C_ADV),
        .page      (page),
        .off       (off),
        .remain    (remain),
        .chunk_len (chunk_len),
        .partial   (partial)
    );

    always_comb begin
        dev_page = DEV_AW'(page) << PAGE_OFS_BITS;
        dev_full = dev_page + DEV_AW'(off);
        f_pay    = '0;
        f_cnt    = 3'd4;
        unique case (st)
            C_LOAD:  f_hdr = pack_cmd(OP_PAGE_TO_BUF, dev_page);
            C_PROG: begin
                f_hdr = pack_cmd(OP_PROG_THRU_BUF, dev_full);
                f_pay = chunk_len;
            end
            C_CMP:   f_hdr = pack_cmd(OP_BUF_COMPARE, dev_page);
            default: begin
                f_hdr = pack_cmd(OP_STATUS, '0);
                f_cnt = 3'd2;
            end
        endcase
        launch = !armed && ((st == C_LOAD) || (st == C_PROG) ||
                            (st == C_CMP)  || (st == C_POLL));
        busy   = (st != C_IDLE);
    end

    pgprog_frame #(.CL_W(CL_W)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .hdr        (f_hdr),
        .hdr_cnt    (f_cnt),
        .pay_cnt    (f_pay),
        .wr_data    (wr_data),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .sel        (link_sel),
        .link_tx    (link_tx),
        .link_valid (link_valid),
        .link_ready (link_ready),
        .link_rx    (link_rx),
        .fin        (fin),
        .rx_last    (rx_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= C_IDLE;
            ret           <= RET_LOAD;
            armed         <= 1'b0;
            verify_q      <= 1'b0;
            done          <= 1'b0;
            bytes_written <= '0;
            cmp_err       <= 1'b0;
            err_page      <= '0;
        end else begin
            done <= 1'b0;
            if (launch) armed <= 1'b1;
            if (fin)    armed <= 1'b0;
            unique case (st)
                C_IDLE: if (start) begin
                    verify_q      <= verify_en;
                    bytes_written <= '0;
                    cmp_err       <= 1'b0;
                    err_page      <= '0;
                    st            <= C_PLAN;
                end
                C_PLAN: begin
                    if (remain == '0) begin
                        done <= 1'b1;
                        st   <= C_IDLE;
                    end else begin
                        st <= partial ? C_LOAD : C_PROG;
                    end
                end
                C_LOAD: if (fin) begin
                    ret <= RET_LOAD;
                    st  <= C_POLL;
                end
                C_PROG: if (fin) begin
                    ret <= RET_PROG;
                    st  <= C_POLL;
                end
                C_CMP: if (fin) begin
                    ret <= RET_CMP;
                    st  <= C_POLL;
                end
                C_POLL: if (fin && rx_last[ST_READY_BIT]) begin
                    unique case (ret)
                        RET_LOAD: st <= C_PROG;
                        RET_PROG: st <= verify_q ? C_CMP : C_ADV;
                        default: begin
                            if (rx_last[ST_MISMATCH_BIT]) begin
                                cmp_err  <= 1'b1;
                                err_page <= page;
                                done     <= 1'b1;
                                st       <= C_IDLE;
                            end else begin
                                st <= C_ADV;
                            end
                        end
                    endcase
                end
                C_ADV: begin
                    bytes_written <= bytes_written + LEN_W'(chunk_len);
                    st            <= C_PLAN;
                end
                default: st <= C_IDLE;
            endcase
        end
    end

    // R9: the stream is only drained by a program step.
    p_stream_only_in_prog_r9: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> (st == C_PROG));

    // R6: a compare failure ends the request in the same cycle.
    p_err_ends_request_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(cmp_err) |-> (done && !busy));

    // R7: the committed count never falls within a request.
    p_count_monotonic_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (bytes_written >= $past(bytes_written)));

    // R10: a request in flight keeps running whatever start does.
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && (st != C_PLAN)) |=> (busy || done));

endmodule

// File: tb/pgprog_ctrl_tb.sv
`timescale 1ns/1ps
module pgprog_ctrl_tb;
    localparam int PS = 6;
    localparam int OB = 3;
    localparam int AW = 8;
    localparam int LW = 8;
    localparam int PAGES = 8;
    localparam int MEMN = PS * PAGES;
    localparam int NV = 6;
    // addr, len, verify, expected program frames, expected load frames
    localparam int VEC [NV][5] = '{
        '{ 0,  6, 0, 1, 0},
        '{ 2,  3, 1, 1, 1},
        '{ 4, 10, 0, 3, 2},
        '{12, 12, 1, 2, 0},
        '{17,  1, 1, 1, 1},
        '{30, 14, 0, 3, 1}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst;
    logic          start;
    logic [AW-1:0] start_addr;
    logic [LW-1:0] byte_len;
    logic          verify_en;
    logic [7:0]    wr_data;
    logic          wr_valid, wr_ready;
    logic          link_sel, link_valid, link_ready;
    logic [7:0]    link_tx, link_rx;
    logic          busy, done, cmp_err;
    logic [LW-1:0] bytes_written;
    logic [AW-1:0] err_page;

    pgprog_ctrl #(.PAGE_SIZE(PS), .PAGE_OFS_BITS(OB), .ADDR_W(AW), .LEN_W(LW)) u_dut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .byte_len(byte_len), .verify_en(verify_en), .wr_data(wr_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .link_sel(link_sel),
        .link_tx(link_tx), .link_valid(link_valid), .link_ready(link_ready),
        .link_rx(link_rx), .busy(busy), .done(done),
        .bytes_written(bytes_written), .cmp_err(cmp_err), .err_page(err_page)
    );

    // ---- device model and monitors ----
    logic [7:0]  mem [MEMN];
    logic [7:0]  pbuf [PS];
    logic [7:0]  exp_mem [MEMN];
    logic [7:0]  op;
    logic [23:0] fa;
    logic        sel_q, mismatch;
    logic [1:0]  rcnt;
    int nb, busy_cnt, cyc;
    int n_load, n_prog, n_cmp, n_frames;
    int v_poll, v_addr, v_ready, v_cnt;
    int bad_page = -1;
    int src_i, src_base = 0, src_lim = 0, seed = 0;
    int n_chk = 0, n_fail = 0;

    function automatic logic [7:0] dbyte(input int s, input int i);
        return 8'(s * 29 + i * 7 + 3);
    endfunction

    assign link_ready = (rcnt != 2'd3);
    assign wr_valid   = (src_i < src_lim) && (cyc % 5 != 2);
    assign wr_data    = dbyte(seed, src_i - src_base);
    assign link_rx    = (op == 8'hD7 && nb == 1) ? {busy_cnt == 0, mismatch, 6'b0} : 8'hFF;

    always @(posedge clk) begin
        int pg, ix;
        logic mm;
        if (rst) begin
            for (int i = 0; i < MEMN; i++) mem[i] <= 8'hA0 ^ 8'(i);
            for (int i = 0; i < PS; i++) pbuf[i] <= 8'h00;
            op <= 8'h00; fa <= '0; sel_q <= 1'b0; mismatch <= 1'b0; rcnt <= '0;
            nb <= 0; busy_cnt <= 0; cyc <= 0; src_i <= 0;
            n_load <= 0; n_prog <= 0; n_cmp <= 0; n_frames <= 0;
            v_poll <= 0; v_addr <= 0; v_ready <= 0; v_cnt <= 0;
        end else begin
            cyc   <= cyc + 1;
            rcnt  <= rcnt + 2'd1;
            sel_q <= link_sel;
            if (wr_valid && wr_ready) src_i <= src_i + 1;
            if (wr_ready && !(link_sel && op == 8'h82 && nb >= 4)) v_ready <= v_ready + 1;
            if (busy && int'(bytes_written) > src_i - src_base) v_cnt <= v_cnt + 1;
            pg = int'(fa[23:OB]);
            if (link_valid && link_ready) begin
                if (nb == 0) begin
                    op <= link_tx;
                    if (busy_cnt > 0 && link_tx != 8'hD7) v_poll <= v_poll + 1;
                end else if (nb <= 3) begin
                    fa <= {fa[15:0], link_tx};
                end else if (op == 8'h82) begin
                    ix = int'(fa[OB-1:0]) + nb - 4;
                    if (ix < PS) pbuf[ix] <= link_tx;
                end
                nb <= nb + 1;
            end
            if (sel_q && !link_sel) begin
                nb <= 0;
                n_frames <= n_frames + 1;
                if (op == 8'h53) begin
                    n_load <= n_load + 1;
                    if (fa[OB-1:0] != '0) v_addr <= v_addr + 1;
                    for (int k = 0; k < PS; k++) if (pg < PAGES) pbuf[k] <= mem[pg*PS+k];
                    busy_cnt <= 2;
                end else if (op == 8'h82) begin
                    n_prog <= n_prog + 1;
                    for (int k = 0; k < PS; k++) if (pg < PAGES) mem[pg*PS+k] <= pbuf[k];
                    if (pg == bad_page) mem[pg*PS] <= pbuf[0] ^ 8'h01;
                    busy_cnt <= 2;
                end else if (op == 8'h60) begin
                    n_cmp <= n_cmp + 1;
                    mm = 1'b0;
                    for (int k = 0; k < PS; k++) if (pg < PAGES && pbuf[k] != mem[pg*PS+k]) mm = 1'b1;
                    mismatch <= mm;
                    busy_cnt <= 1;
                end else if (op == 8'hD7) begin
                    if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
                end
            end
        end
    end

    // ---- checking helpers ----
    task automatic check(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic run_req(input int a, input int l, input int v, output int lat);
        for (int i = 0; i < l; i++) if (a + i < MEMN) exp_mem[a + i] = dbyte(seed, i);
        @(negedge clk);
        src_base = src_i; src_lim = src_i + l;
        start = 1'b1; start_addr = AW'(a); byte_len = LW'(l); verify_en = v[0];
        lat = -1;
        for (int k = 1; k <= 20000; k++) begin
            @(negedge clk);
            if (k == 1) start = 1'b0;
            if (done) begin lat = k; break; end
        end
        if (lat < 0) check("R7 done timeout", 0, 1);
    endtask

    function automatic int mem_diffs(input int lo, input int hi);
        int d = 0;
        for (int i = lo; i < hi; i++) if (mem[i] !== exp_mem[i]) d++;
        return d;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int lat, b_load, b_prog, b_cmp, b_fr;
        for (int i = 0; i < MEMN; i++) exp_mem[i] = 8'hA0 ^ 8'(i);
        rst = 1'b1; start = 1'b0; start_addr = '0; byte_len = '0; verify_en = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 link_sel", int'(link_sel), 0);
        check("R1 link_valid", int'(link_valid), 0);
        check("R1 wr_ready", int'(wr_ready), 0);
        check("R1 bytes_written", int'(bytes_written), 0);
        check("R1 cmp_err", int'(cmp_err), 0);

        // vector table: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            seed = v + 1;
            b_load = n_load; b_prog = n_prog; b_cmp = n_cmp;
            run_req(VEC[v][0], VEC[v][1], VEC[v][2], lat);
            check("R7 bytes_written", int'(bytes_written), VEC[v][1]);
            check("R2 program frames", n_prog - b_prog, VEC[v][3]);
            check("R3 load frames", n_load - b_load, VEC[v][4]);
            check("R6 compare frames", n_cmp - b_cmp, VEC[v][2] * VEC[v][3]);
            check("R6 no cmp_err", int'(cmp_err), 0);
            check("R4 memory image", mem_diffs(0, MEMN), 0);
            check("R5 device idle at done", busy_cnt, 0);
            check("R7 busy low at done", int'(busy), 0);
        end

        // R8: zero length
        seed = 20;
        b_fr = n_frames;
        run_req(5, 0, 1, lat);
        check("R8 done latency", lat, 2);
        check("R8 no frames", n_frames - b_fr, 0);
        check("R8 bytes_written", int'(bytes_written), 0);

        // R6: compare failure on page 2
        seed = 21; bad_page = 2;
        b_prog = n_prog; b_cmp = n_cmp;
        run_req(6, 12, 1, lat);
        check("R6 cmp_err", int'(cmp_err), 1);
        check("R6 err_page", int'(err_page), 2);
        check("R7 count excludes failed chunk", int'(bytes_written), 6);
        check("R6 program frames", n_prog - b_prog, 2);
        check("R6 compare frames", n_cmp - b_cmp, 2);
        check("R4 good page intact", mem_diffs(0, 12), 0);
        src_lim = src_i;
        b_fr = n_frames;
        repeat (30) @(negedge clk);
        check("R6 no frames after error", n_frames - b_fr, 0);
        check("R6 busy after error", int'(busy), 0);
        for (int i = 12; i < 18; i++) exp_mem[i] = mem[i];
        bad_page = -1;

        // R6: stale mismatch bit ignored when verify is off
        seed = 22;
        b_load = n_load;
        run_req(20, 4, 0, lat);
        check("R6 stale mismatch ignored", int'(cmp_err), 0);
        check("R3 partial load", n_load - b_load, 1);
        check("R4 memory after partial", mem_diffs(0, MEMN), 0);

        // R10: start while busy is ignored
        seed = 23;
        for (int i = 0; i < 8; i++) exp_mem[24 + i] = dbyte(seed, i);
        b_prog = n_prog;
        @(negedge clk);
        src_base = src_i; src_lim = src_i + 8;
        start = 1'b1; start_addr = AW'(24); byte_len = LW'(8); verify_en = 1'b0;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        start = 1'b1; start_addr = AW'(40); byte_len = LW'(3); verify_en = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = -1;
        for (int k = 0; k < 20000; k++) begin
            if (done) begin lat = k; break; end
            @(negedge clk);
        end
        check("R10 finished", int'(lat >= 0), 1);
        check("R10 bytes_written", int'(bytes_written), 8);
        check("R10 program frames", n_prog - b_prog, 2);
        check("R10 memory untouched elsewhere", mem_diffs(0, MEMN), 0);

        // monitors over the whole run
        check("R5 command issued while busy", v_poll, 0);
        check("R3 load address offset bits", v_addr, 0);
        check("R9 wr_ready outside data", v_ready, 0);
        check("R7 count ahead of stream", v_cnt, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule